// File: doc/BRIEF.md
# Impedance Calibration Search Controller

This block finds an impedance compensation code by a closed feedback loop. It drives a 7-bit code to an analog comparator front end and waits for the front end to settle. It then samples a single direction bit from the comparator and moves the code one step up or down. The settling time is chosen by a 3-bit select that maps to a non-linear set of clock-cycle counts. Before the first sample of every calibration cycle the controller waits eight times the selected time.

A cycle ends after a fixed number of steps, or sooner once the sampled direction has flipped on two samples in a row. The final code is then stored in a result register and a one-cycle done pulse is raised. One cycle runs on its own when reset is released, unless a disable input holds it off. Later cycles start on a start pulse, but only when the calibration-enable control is set.

Three receiver ports each receive an update code. For each port, a separate override bit chooses between the calibrated result and a code supplied by software. The block holds the configuration controls itself. A single write strobe loads all of them at once.

Top module: `impcal_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, `cal_code_o` and `result_o` equal the initial code 64, every port field equals 64, and `busy_o` and `done_o` are 0.
- R2: If `init_dis_i` is low on the first clock edge after reset is released, a calibration cycle starts on that edge without any start pulse. If it is high, no cycle starts.
- R3: `start_i` starts a cycle only when the block is idle and the calibration-enable control is 1. A start pulse while busy, or while the enable is 0, has no effect.
- R4: Settling select values 0 to 7 give waits of 5, 6, 7, 8, 9, 10, 13 and 15 clock cycles. The first code change comes 8×D edges after the start edge, and each later sample comes D edges after the one before.
- R5: On each sample, `cmp_up_i` = 1 raises the code by one and `cmp_up_i` = 0 lowers it by one.
- R6: The code saturates: an up sample at 127 leaves it at 127, and a down sample at 0 leaves it at 0.
- R7: A cycle ends on its 16th sample, or earlier on a sample whose direction differs from the previous one when the previous sample had also differed from the one before it. `busy_o` is low from the edge that ends the cycle.
- R8: When a cycle ends, `result_o` takes the final code and `done_o` is high for exactly one cycle, in the same cycle that the new result is visible. At other times `result_o` holds its value.
- R9: Port k takes bits [7k+6:7k] of `port_code_o`. It carries the override code when override-enable bit k is set, and the calibrated result otherwise.
- R10: The port outputs change only on the edge that raises `done_o`, or on an edge where `cfg_we_i` is high. If both happen on one edge, the newly written override settings apply together with the new result.
- R11: The configuration controls reset to: calibration enable 1, settling select 0, override enables 0, override code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Write strobe that loads all configuration controls |
| cfg_cal_en_i | input | 1 | New calibration-enable value |
| cfg_dly_sel_i | input | 3 | New settling-time select |
| cfg_ovr_en_i | input | NPORT | New per-port override enables |
| cfg_ovr_code_i | input | CODE_W | New software override code |
| init_dis_i | input | 1 | Suppresses the automatic cycle after reset |
| start_i | input | 1 | Request for a periodic calibration cycle |
| cmp_up_i | input | 1 | Comparator direction: 1 = raise code, 0 = lower code |
| cal_code_o | output | CODE_W | Code driven to the front end |
| busy_o | output | 1 | A calibration cycle is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a cycle |
| result_o | output | CODE_W | Stored calibration result |
| port_code_o | output | NPORT*CODE_W | Update codes for the receiver ports |

## Verification
The end of a calibration cycle and a write of the override controls can land on the same clock edge. Both then load the port registers. The bench uses its own model of the search to predict the exact edge on which the cycle ends. It then drives the write strobe in the cycle just before that edge. The result is judged by comparing every port field against the newly written enables and code, together with the newly found result. It also checks that no port moved during the run before that edge.

// File: rtl/impcal_pkg.sv
package impcal_pkg;

  localparam int SEL_W = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cal_state_t;

  // Settling time in picoseconds for each select value.
  function automatic int settle_ps(input int sel);
    case (sel)
      0:       return 50_000;
      1:       return 60_000;
      2:       return 70_000;
      3:       return 80_000;
      4:       return 90_000;
      5:       return 100_000;
      6:       return 125_000;
      default: return 150_000;
    endcase
  endfunction

  // Clock cycles covering the settling time (rounded up).
  function automatic int dly_cycles(input int sel, input int clk_ps);
    return (settle_ps(sel) + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int dly_max(input int clk_ps);
    int m;
    m = 0;
    for (int s = 0; s < (1 << SEL_W); s++)
      if (dly_cycles(s, clk_ps) > m) m = dly_cycles(s, clk_ps);
    return m;
  endfunction

endpackage

// File: rtl/impcal_dly_dec.sv
module impcal_dly_dec #(
  parameter int CLK_PS = 10000,
  parameter int DLY_W  = 4
) (
  input  logic [impcal_pkg::SEL_W-1:0] sel_i,
  output logic [DLY_W-1:0]             cycles_o
);

  always_comb begin
    cycles_o = DLY_W'(impcal_pkg::dly_cycles(int'(sel_i), CLK_PS));
  end

endmodule

// File: rtl/impcal_engine.sv
module impcal_engine #(
  parameter int CODE_W    = 7,
  parameter int DLY_W     = 4,
  parameter int MAX_STEPS = 16,
  parameter int INIT_CODE = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cal_en_i,
  input  logic              init_dis_i,
  input  logic              cmp_up_i,
  input  logic [DLY_W-1:0]  dly_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] code_nxt_o,
  output logic [CODE_W-1:0] result_o,
  output logic              fin_o,
  output logic              done_o,
  output logic              busy_o
);

  import impcal_pkg::*;

  localparam int CNT_W  = DLY_W + 3;
  localparam int STEP_W = $clog2(MAX_STEPS + 1);
  localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

  cal_state_t        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [STEP_W-1:0] step_q;
  logic [CODE_W-1:0] code_q, result_q;
  logic              first_pend_q, prev_dir_q, have_prev_q, flip_prev_q, done_q;

  logic sample, flip, launch;
  logic [CODE_W-1:0] step_code;

  always_comb begin
    sample = (st_q == ST_RUN) && (cnt_q == CNT_W'(1));
    flip   = have_prev_q && (cmp_up_i != prev_dir_q);
    if (cmp_up_i) step_code = (code_q == CODE_TOP) ? code_q : code_q + 1'b1;
    else          step_code = (code_q == '0) ? code_q : code_q - 1'b1;
    fin_o  = sample && ((flip && flip_prev_q) || (step_q == STEP_W'(MAX_STEPS - 1)));
    launch = (st_q == ST_IDLE) &&
             (first_pend_q ? !init_dis_i : (start_i && cal_en_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      cnt_q        <= '0;
      step_q       <= '0;
      code_q       <= CODE_W'(INIT_CODE);
      result_q     <= CODE_W'(INIT_CODE);
      first_pend_q <= 1'b1;
      prev_dir_q   <= 1'b0;
      have_prev_q  <= 1'b0;
      flip_prev_q  <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      done_q <= fin_o;
      if (st_q == ST_IDLE) begin
        first_pend_q <= 1'b0;
        if (launch) begin
          st_q        <= ST_RUN;
          cnt_q       <= {dly_i, 3'b000};
          step_q      <= '0;
          have_prev_q <= 1'b0;
          flip_prev_q <= 1'b0;
        end
      end else if (sample) begin
        code_q      <= step_code;
        prev_dir_q  <= cmp_up_i;
        have_prev_q <= 1'b1;
        flip_prev_q <= flip;
        step_q      <= step_q + 1'b1;
        cnt_q       <= {3'b000, dly_i};
        if (fin_o) begin
          st_q     <= ST_IDLE;
          result_q <= step_code;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign code_o     = code_q;
  assign code_nxt_o = step_code;
  assign result_o   = result_q;
  assign done_o     = done_q;
  assign busy_o     = (st_q == ST_RUN);

endmodule

// File: rtl/impcal_port_mux.sv
module impcal_port_mux #(
  parameter int CODE_W    = 7,
  parameter int NPORT     = 3,
  parameter int INIT_CODE = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_i,
  input  logic [NPORT-1:0]        ovr_en_i,
  input  logic [CODE_W-1:0]       ovr_code_i,
  input  logic [CODE_W-1:0]       cal_code_i,
  output logic [NPORT*CODE_W-1:0] port_code_o
);

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst)        code_q <= CODE_W'(INIT_CODE);
      else if (upd_i) code_q <= ovr_en_i[k] ? ovr_code_i : cal_code_i;
    end
    assign port_code_o[k*CODE_W +: CODE_W] = code_q;
  end

endmodule

// File: rtl/impcal_ctrl.sv
module impcal_ctrl #(
  parameter int CODE_W    = 7,
  parameter int NPORT     = 3,
  parameter int MAX_STEPS = 16,
  parameter int INIT_CODE = 64,
  parameter int CLK_PS    = 10000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we_i,
  input  logic                          cfg_cal_en_i,
  input  logic [impcal_pkg::SEL_W-1:0]  cfg_dly_sel_i,
  input  logic [NPORT-1:0]              cfg_ovr_en_i,
  input  logic [CODE_W-1:0]             cfg_ovr_code_i,
  input  logic                          init_dis_i,
  input  logic                          start_i,
  input  logic                          cmp_up_i,
  output logic [CODE_W-1:0]             cal_code_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [CODE_W-1:0]             result_o,
  output logic [NPORT*CODE_W-1:0]       port_code_o
);

  import impcal_pkg::*;

  localparam int MAXD  = dly_max(CLK_PS);
  localparam int DLY_W = $clog2(MAXD + 1);

  logic                 cal_en_q;
  logic [SEL_W-1:0]     sel_q;
  logic [NPORT-1:0]     ovr_en_q;
  logic [CODE_W-1:0]    ovr_code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_en_q   <= 1'b1;
      sel_q      <= '0;
      ovr_en_q   <= '0;
      ovr_code_q <= '0;
    end else if (cfg_we_i) begin
      cal_en_q   <= cfg_cal_en_i;
      sel_q      <= cfg_dly_sel_i;
      ovr_en_q   <= cfg_ovr_en_i;
      ovr_code_q <= cfg_ovr_code_i;
    end
  end

  logic [DLY_W-1:0]  dly;
  logic [CODE_W-1:0] code_nxt, result_q;
  logic              fin;

  impcal_dly_dec #(.CLK_PS(CLK_PS), .DLY_W(DLY_W)) u_dly (
    .sel_i    (sel_q),
    .cycles_o (dly)
  );

  impcal_engine #(
    .CODE_W(CODE_W), .DLY_W(DLY_W), .MAX_STEPS(MAX_STEPS), .INIT_CODE(INIT_CODE)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cal_en_i   (cal_en_q),
    .init_dis_i (init_dis_i),
    .cmp_up_i   (cmp_up_i),
    .dly_i      (dly),
    .code_o     (cal_code_o),
    .code_nxt_o (code_nxt),
    .result_o   (result_q),
    .fin_o      (fin),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );

  // A write and a finishing sample on one edge combine: new settings, new result.
  logic [NPORT-1:0]  eff_en;
  logic [CODE_W-1:0] eff_code, eff_res;

  always_comb begin
    eff_en   = cfg_we_i ? cfg_ovr_en_i   : ovr_en_q;
    eff_code = cfg_we_i ? cfg_ovr_code_i : ovr_code_q;
    eff_res  = fin ? code_nxt : result_q;
  end

  impcal_port_mux #(.CODE_W(CODE_W), .NPORT(NPORT), .INIT_CODE(INIT_CODE)) u_mux (
    .clk         (clk),
    .rst         (rst),
    .upd_i       (cfg_we_i | fin),
    .ovr_en_i    (eff_en),
    .ovr_code_i  (eff_code),
    .cal_code_i  (eff_res),
    .port_code_o (port_code_o)
  );

  assign result_o = result_q;

endmodule

// File: rtl/impcal_ctrl_chk.sv
module impcal_ctrl_chk #(
  parameter int CODE_W    = 7,
  parameter int NPORT     = 3,
  parameter int INIT_CODE = 64
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cfg_we_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic [CODE_W-1:0]       cal_code_o,
  input logic [CODE_W-1:0]       result_o,
  input logic [NPORT*CODE_W-1:0] port_code_o
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cal_code_o == CODE_W'(INIT_CODE) && result_o == CODE_W'(INIT_CODE)
             && !busy_o && !done_o));

  // R5
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cal_code_o != $past(cal_code_o)) |->
      ((int'(cal_code_o) - int'($past(cal_code_o)) == 1) ||
       (int'(cal_code_o) - int'($past(cal_code_o)) == -1)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  done_result_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (result_o == cal_code_o));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R10
  port_change_chk: assert property (@(posedge clk) disable iff (rst)
    (port_code_o != $past(port_code_o)) |-> (done_o || $past(cfg_we_i)));

endmodule

bind impcal_ctrl impcal_ctrl_chk #(
  .CODE_W(CODE_W), .NPORT(NPORT), .INIT_CODE(INIT_CODE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_we_i    (cfg_we_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .cal_code_o  (cal_code_o),
  .result_o    (result_o),
  .port_code_o (port_code_o)
);

// File: tb/impcal_ctrl_tb.sv
`timescale 1ns/1ps
module impcal_ctrl_tb;

  localparam int CW = 7, NP = 3, MAXS = 16, INIT = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0, cfg_cal_en = 1'b1, init_dis = 1'b1, start = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [NP-1:0] cfg_en = '0;
  logic [CW-1:0] cfg_code = '0;
  logic cmp_up, busy, done;
  logic [CW-1:0] cal_code, result;
  logic [NP*CW-1:0] port_code;

  int mode = 0, tgt = 0;
  int errs = 0, checks = 0;
  bit [NP-1:0] m_en = '0;
  int m_code = 0, m_sel = 0, m_res = INIT;

  always #2.5 clk = ~clk;

  assign cmp_up = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : (int'(cal_code) < tgt);

  impcal_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_cal_en_i(cfg_cal_en),
    .cfg_dly_sel_i(cfg_sel), .cfg_ovr_en_i(cfg_en), .cfg_ovr_code_i(cfg_code),
    .init_dis_i(init_dis), .start_i(start), .cmp_up_i(cmp_up),
    .cal_code_o(cal_code), .busy_o(busy), .done_o(done), .result_o(result),
    .port_code_o(port_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dly_of(input int sel);
    case (sel)
      0: return 5;  1: return 6;  2: return 7;  3: return 8;
      4: return 9;  5: return 10; 6: return 13; default: return 15;
    endcase
  endfunction

  function automatic bit dir_of(input int md, input int c, input int t);
    if (md == 1) return 1'b1;
    if (md == 2) return 1'b0;
    return c < t;
  endfunction

  // Search model from R5, R6, R7.
  task automatic model(input int c0, input int md, input int t, output int cf, output int n);
    int c; bit pd, hp, fp, d, fl;
    c = c0; hp = 0; fp = 0; pd = 0; n = 0;
    for (int s = 1; s <= MAXS; s++) begin
      d = dir_of(md, c, t);
      if (d) c = (c == 127) ? 127 : c + 1;
      else   c = (c == 0) ? 0 : c - 1;
      fl = hp && (d != pd);
      n = s;
      if ((fl && fp) || s == MAXS) break;
      pd = d; hp = 1; fp = fl;
    end
    cf = c;
  endtask

  task automatic chk_ports(input string tag);
    int e;
    for (int k = 0; k < NP; k++) begin
      e = m_en[k] ? m_code : m_res;
      chk(int'(port_code[k*CW +: CW]) == e, tag, int'(port_code[k*CW +: CW]), e);
    end
  endtask

  task automatic cfg_wr(input bit ce, input int sel, input bit [NP-1:0] en, input int code);
    @(negedge clk);
    cfg_we = 1; cfg_cal_en = ce; cfg_sel = 3'(sel); cfg_en = en; cfg_code = CW'(code);
    @(negedge clk);
    cfg_we = 0;
    m_sel = sel; m_en = en; m_code = code;
    chk_ports("R9 port mux after write");
  endtask

  // auto=1: the cycle is launched by reset release instead of start_i.
  task automatic run_cal(input int md, input int t, input bit ign, input bit coll,
                         input bit auto, input bit [NP-1:0] c_en, input int c_code);
    int c0, cf, n, d, total, k, k1, dk;
    bit stable, moves;
    logic [NP*CW-1:0] p0;
    c0 = auto ? INIT : int'(cal_code);
    model(c0, md, t, cf, n);
    d = dly_of(m_sel);
    total = 8 * d + (n - 1) * d;
    moves = dir_of(md, c0, t) ? (c0 != 127) : (c0 != 0);
    mode = md; tgt = t;
    @(negedge clk);
    p0 = port_code;
    if (auto) rst = 0; else start = 1;
    @(posedge clk);
    k = 0; k1 = -1; dk = -1; stable = 1;
    while (k < total + 20) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      start = 0; cfg_we = 0;
      if (k1 < 0 && int'(cal_code) != c0) k1 = k;
      if (done) begin dk = k; break; end
      if (port_code != p0) stable = 0;
      if (ign && k == 4) start = 1;
      if (coll && k == total - 1) begin
        cfg_we = 1; cfg_cal_en = 1; cfg_sel = 3'(m_sel); cfg_en = c_en; cfg_code = CW'(c_code);
      end
    end
    start = 0; cfg_we = 0;
    if (coll) begin m_en = c_en; m_code = c_code; end
    m_res = cf;
    chk(dk == total, auto ? "R2 auto cycle end time" : "R7 cycle end time", dk, total);
    chk(int'(result) == cf, "R7 final result", int'(result), cf);
    chk(int'(cal_code) == cf, "R5 final code", int'(cal_code), cf);
    if (moves) chk(k1 == 8 * d, "R4 first sample at 8xD", k1, 8 * d);
    chk(stable, "R10 ports steady during run", int'(stable), 1);
    chk_ports(coll ? "R10 write and done on one edge" : "R9 ports after done");
    chk(!busy, "R7 idle after end", int'(busy), 0);
    @(negedge clk);
    chk(!done, "R8 done single cycle", int'(done), 0);
    if (ign) begin
      stable = 1;
      repeat (40) begin
        @(negedge clk);
        if (busy || done) stable = 0;
      end
      chk(stable, "R3 start while busy ignored", int'(stable), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int r, t, md, sel;
    bit ok;
    logic [CW-1:0] c_hold;
    r = int'($urandom(32'd4242));

    // R1, R11: reset state; R2 disabled case
    init_dis = 1;
    repeat (3) @(negedge clk);
    chk(int'(cal_code) == INIT, "R1 code at reset", int'(cal_code), INIT);
    chk(int'(result) == INIT, "R1 result at reset", int'(result), INIT);
    chk(!busy && !done, "R1 busy/done at reset", int'({busy, done}), 0);
    chk_ports("R11 ports at reset");
    rst = 0;
    ok = 1;
    repeat (60) begin
      @(negedge clk);
      if (busy) ok = 0;
    end
    chk(ok, "R2 disabled first cycle", int'(ok), 1);

    // R2: automatic cycle after reset
    @(negedge clk); rst = 1; init_dis = 0;
    m_en = '0; m_code = 0; m_sel = 0; m_res = INIT;
    repeat (3) @(negedge clk);
    run_cal(0, 70, 0, 0, 1, '0, 0);
    init_dis = 1;

    // R11: enable defaults to 1, start accepted without a write
    run_cal(0, 40, 0, 0, 0, '0, 0);

    // R4: each settling select
    for (int s = 0; s < 8; s++) begin
      cfg_wr(1, s, '0, 0);
      run_cal(0, (s % 2) ? 20 : 100, 0, 0, 0, '0, 0);
    end

    // R3: start ignored while busy
    cfg_wr(1, 0, '0, 0);
    run_cal(0, 90, 1, 0, 0, '0, 0);

    // R3: start ignored while disabled
    cfg_wr(0, 0, '0, 0);
    c_hold = cal_code;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    ok = 1;
    repeat (40) begin
      @(negedge clk);
      if (busy || cal_code != c_hold) ok = 0;
    end
    chk(ok, "R3 start ignored when disabled", int'(ok), 1);
    cfg_wr(1, 0, '0, 0);

    // R6: saturation at both ends
    for (int i = 0; i < 9; i++) run_cal(1, 0, 0, 0, 0, '0, 0);
    chk(int'(cal_code) == 127, "R6 saturate high", int'(cal_code), 127);
    for (int i = 0; i < 9; i++) run_cal(2, 0, 0, 0, 0, '0, 0);
    chk(int'(cal_code) == 0, "R6 saturate low", int'(cal_code), 0);

    // R9, R10: overrides, then collision of write and done
    cfg_wr(1, 1, 3'b010, 21);
    run_cal(0, 50, 0, 0, 0, '0, 0);
    run_cal(0, 30, 0, 1, 0, 3'b101, 99);

    // Random mix
    for (int i = 0; i < 20; i++) begin
      sel = int'($urandom_range(0, 7));
      cfg_wr(1, sel, NP'($urandom_range(0, 7)), int'($urandom_range(0, 127)));
      md = (i % 7 == 3) ? int'($urandom_range(1, 2)) : 0;
      t  = int'($urandom_range(0, 127));
      run_cal(md, t, 0, (i % 5 == 2), 0, NP'($urandom_range(0, 7)),
              int'($urandom_range(0, 127)));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule